// File: doc/BRIEF.md
# Multi-rate time-slot interchange switch

This block is a TDM time-slot interchange core. Serial input streams are turned into bytes, one per channel, and each byte is stored in a data memory that has two banks and swaps banks at every frame boundary. The serial output streams are rebuilt one channel at a time. The byte for each output channel comes from a connection memory that a CPU writes. Each connection memory entry names the source stream, the source channel and a delay mode for one output channel.

A rate select chooses the line rate. At 2.048 Mb/s the line carries 32 channels per stream and each bit lasts two clocks. At 4.096 Mb/s it carries 64 channels with one clock per bit. At 8.192 Mb/s it carries 128 channels with one clock per bit. At the two lower rates a configuration bit chooses how many input and output streams are active. At the top rate that bit is ignored. Each output channel can use variable delay, which gives the lowest latency. It can instead use constant delay, where every channel of a frame comes from the same earlier input frame.

Top module: `tsi_switch`

## Requirements
- R1: While reset is held, and after reset until the first channel load, every output stream is high.
- R2: With `rate`=0 a frame has 32 channels and each bit lasts 2 clocks. The input is sampled on the first clock of the bit, and each output bit is held for both clocks. `cfg`=0 gives 8 inputs and 8 outputs. `cfg`=1 gives inputs 0..3 and outputs 0..3.
- R3: With `rate`=1 a frame has 64 channels at 1 clock per bit. `cfg`=0 gives 4 inputs and 4 outputs. `cfg`=1 gives 8 inputs and 4 outputs.
- R4: With `rate`=2 or 3 a frame has 128 channels at 1 clock per bit, with 2 inputs and 2 outputs. `cfg` has no effect.
- R5: When `fp` is high at a clock edge, the bit and channel count restarts. Bit 7 (MSB first) of channel 0 is sampled on the next edge. The output bits of a channel occupy the same clock periods as the input bits of that channel.
- R6: A write with `cm_we` high stores `cm_wdata` at `cm_addr`. The address is {output stream[9:7], output channel[6:0]}. The entry holds valid in bit [11], constant delay in bit [10], source stream in bits [9:7] and source channel in bits [6:0].
- R7: For a variable-delay channel, output channel n of frame F carries source channel sc of input frame F when sc < n. Otherwise it carries input frame F-1.
- R8: For a constant-delay channel, output frame F carries input frame F-1 in every channel. In the 8-input, 4-output configuration (`rate`=1, `cfg`=1) the constant bit is ignored and the channel behaves as variable delay.
- R9: An output channel carries 8'hFF when its entry is not valid, its source stream is not an active input, or its source channel is at or beyond the channel count.
- R10: Output streams outside the active output count stay high.
- R11: When no frame pulse arrives, the frame counter wraps by itself after 512 clocks (`rate` 0 or 1) or after 1024 clocks (`rate` 2 or 3), and switching carries on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fp | input | 1 | Frame pulse, restarts the frame count |
| rate | input | 2 | Line rate: 0 = 2.048, 1 = 4.096, 2/3 = 8.192 Mb/s |
| cfg | input | 1 | Stream configuration select for rates 0 and 1 |
| si | input | 8 | Serial input streams |
| so | output | 8 | Serial output streams |
| cm_we | input | 1 | Connection memory write strobe |
| cm_addr | input | 10 | Connection memory address {stream, channel} |
| cm_wdata | input | 12 | Connection memory entry |

## Verification
The main stimulus is random input bytes in every channel, switched through a random connection map that includes entries that are invalid or out of range. This shows up wrong addressing, wrong bit order and wrong handling of unconnected channels. Directed entries on output stream 0 pick sources just below, at and above the output channel, and the last channel of the previous frame. These entries separate the current-frame path of variable delay from the previous-frame path of constant delay. Each rate and configuration pair runs as its own segment, so that channel count, bit length and active stream counts are each tested. The blocking configuration shows that its constant bit is ignored. A final segment without repeated frame pulses exercises the counter's own wrap.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  // channels per stream for a rate code
  function automatic int f_nch(logic [1:0] r);
    case (r)
      2'd0:    return 32;
      2'd1:    return 64;
      default: return 128;
    endcase
  endfunction

  // 1 when every bit lasts two clocks
  function automatic int f_shift(logic [1:0] r);
    return (r == 2'd0) ? 1 : 0;
  endfunction

  function automatic int f_nin(logic [1:0] r, logic c);
    case (r)
      2'd0:    return c ? 4 : 8;
      2'd1:    return c ? 8 : 4;
      default: return 2;
    endcase
  endfunction

  function automatic int f_nout(logic [1:0] r, logic c);
    case (r)
      2'd0:    return c ? 4 : 8;
      2'd1:    return 4;
      default: return 2;
    endcase
  endfunction

  // constant delay offered only by non-blocking arrangements
  function automatic logic f_const_ok(logic [1:0] r, logic c);
    return !((r == 2'd1) && c);
  endfunction

  function automatic int f_flast(logic [1:0] r, int bits_per_ch);
    return ((f_nch(r) * bits_per_ch) << f_shift(r)) - 1;
  endfunction

endpackage

// File: rtl/tsi_timing.sv
module tsi_timing
  import tsi_pkg::*;
#(
  parameter int CW  = 7,
  parameter int BW  = 3,
  localparam int CYW = CW + BW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fp,
  input  logic [1:0]     rate,
  output logic [CYW-1:0] cyc,
  output logic [CYW-1:0] flast,
  output logic [CW-1:0]  cur_ch,
  output logic [BW-1:0]  bitpos,
  output logic           sample,
  output logic           ch_end,
  output logic           last_ch,
  output logic           frame_end,
  output logic           wbank
);
  logic           slow;
  logic [CYW-1:0] bitidx;

  assign slow      = (f_shift(rate) == 1);
  assign flast     = CYW'(f_flast(rate, 1 << BW));
  assign bitidx    = slow ? (cyc >> 1) : cyc;
  assign bitpos    = bitidx[BW-1:0];
  assign cur_ch    = bitidx[CYW-1:BW];
  assign sample    = !slow || !cyc[0];
  assign ch_end    = (&bitpos) && (!slow || cyc[0]);
  assign last_ch   = (cur_ch == CW'(f_nch(rate) - 1));
  assign frame_end = fp || (cyc == flast);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc   <= '0;
      wbank <= 1'b0;
    end else begin
      cyc   <= frame_end ? '0 : cyc + 1'b1;
      if (frame_end) wbank <= !wbank;
    end
  end
endmodule

// File: rtl/tsi_cmem.sv
module tsi_cmem #(
  parameter int NSTREAM = 8,
  parameter int CW      = 7,
  localparam int SW     = $clog2(NSTREAM),
  localparam int EW     = 2 + SW + CW
) (
  input  logic                        clk,
  input  logic                        we,
  input  logic [SW+CW-1:0]            waddr,
  input  logic [EW-1:0]               wdata,
  input  logic [CW-1:0]               rd_ch,
  output logic [NSTREAM-1:0][EW-1:0]  rd_ent
);
  logic [EW-1:0] mem [0:(1<<(SW+CW))-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar o = 0; o < NSTREAM; o++) begin : g_rd
    assign rd_ent[o] = mem[{SW'(o), rd_ch}];
  end
endmodule

// File: rtl/tsi_dmem.sv
module tsi_dmem
  import tsi_pkg::*;
#(
  parameter int NSTREAM = 8,
  parameter int CW      = 7,
  parameter int DW      = 8,
  localparam int SW     = $clog2(NSTREAM),
  localparam int EW     = 2 + SW + CW
) (
  input  logic                        clk,
  input  logic                        we,
  input  logic                        wbank,
  input  logic [CW-1:0]               cur_ch,
  input  logic                        last_ch,
  input  logic [1:0]                  rate,
  input  logic                        cfg,
  input  logic [NSTREAM-1:0][DW-1:0]  in_byte,
  input  logic [NSTREAM-1:0][EW-1:0]  ent,
  output logic [NSTREAM-1:0][DW-1:0]  rd_byte
);
  logic [DW-1:0] mem [0:1][0:(1<<(SW+CW))-1];
  logic [SW:0]   nin;
  logic [CW-1:0] nch_m1;
  logic          cok;

  assign nin    = (SW+1)'(f_nin(rate, cfg));
  assign nch_m1 = CW'(f_nch(rate) - 1);
  assign cok    = f_const_ok(rate, cfg);

  always_ff @(posedge clk) begin
    if (we) begin
      for (int s = 0; s < NSTREAM; s++) mem[wbank][{SW'(s), cur_ch}] <= in_byte[s];
    end
  end

  for (genvar o = 0; o < NSTREAM; o++) begin : g_rd
    logic [SW-1:0] ss;
    logic [CW-1:0] sc;
    logic          ok, use_new, bank;
    assign ss      = ent[o][SW+CW-1:CW];
    assign sc      = ent[o][CW-1:0];
    assign ok      = ent[o][EW-1] && ({1'b0, ss} < nin) && (sc <= nch_m1);
    // newest copy, except constant delay mid-frame keeps to the older bank
    assign use_new = !(ent[o][EW-2] && cok) || last_ch;
    assign bank    = (use_new && (sc < cur_ch)) ? wbank : !wbank;
    assign rd_byte[o] = !ok ? '1 :
                        (use_new && (sc == cur_ch)) ? in_byte[ss] : mem[bank][{ss, sc}];
  end
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int NSTREAM = 8,
  parameter int MAXCH   = 128,
  parameter int DW      = 8,
  localparam int SW     = $clog2(NSTREAM),
  localparam int CW     = $clog2(MAXCH),
  localparam int BW     = $clog2(DW),
  localparam int CYW    = CW + BW,
  localparam int EW     = 2 + SW + CW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fp,
  input  logic [1:0]         rate,
  input  logic               cfg,
  input  logic [NSTREAM-1:0] si,
  output logic [NSTREAM-1:0] so,
  input  logic               cm_we,
  input  logic [SW+CW-1:0]   cm_addr,
  input  logic [EW-1:0]      cm_wdata
);
  logic [CYW-1:0] cyc, flast;
  logic [CW-1:0]  cur_ch, next_ch;
  logic [BW-1:0]  bitpos;
  logic           sample, ch_end, last_ch, frame_end, wbank, slow;
  logic [NSTREAM-1:0][DW-1:0] shreg, in_byte, rd_byte, obyte;
  logic [NSTREAM-1:0][EW-1:0] ent;

  tsi_timing #(.CW(CW), .BW(BW)) u_tim (
    .clk(clk), .rst_n(rst_n), .fp(fp), .rate(rate), .cyc(cyc), .flast(flast),
    .cur_ch(cur_ch), .bitpos(bitpos), .sample(sample), .ch_end(ch_end),
    .last_ch(last_ch), .frame_end(frame_end), .wbank(wbank));

  assign slow    = (f_shift(rate) == 1);
  assign next_ch = last_ch ? '0 : cur_ch + 1'b1;

  // input deserialisers
  for (genvar s = 0; s < NSTREAM; s++) begin : g_in
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      shreg[s] <= '0;
      else if (sample) shreg[s] <= {shreg[s][DW-2:0], si[s]};
    end
    assign in_byte[s] = slow ? shreg[s] : {shreg[s][DW-2:0], si[s]};
  end

  tsi_cmem #(.NSTREAM(NSTREAM), .CW(CW)) u_cm (
    .clk(clk), .we(cm_we), .waddr(cm_addr), .wdata(cm_wdata),
    .rd_ch(next_ch), .rd_ent(ent));

  tsi_dmem #(.NSTREAM(NSTREAM), .CW(CW), .DW(DW)) u_dm (
    .clk(clk), .we(ch_end), .wbank(wbank), .cur_ch(cur_ch), .last_ch(last_ch),
    .rate(rate), .cfg(cfg), .in_byte(in_byte), .ent(ent), .rd_byte(rd_byte));

  // output serialisers
  for (genvar o = 0; o < NSTREAM; o++) begin : g_out
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      obyte[o] <= '1;
      else if (ch_end) obyte[o] <= rd_byte[o];
    end
    assign so[o] = (o < f_nout(rate, cfg)) ? obyte[o][~bitpos] : 1'b1;
  end
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk
  import tsi_pkg::*;
#(
  parameter int NSTREAM = 8,
  parameter int CYW     = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fp,
  input logic [1:0]         rate,
  input logic               cfg,
  input logic [NSTREAM-1:0] so,
  input logic [CYW-1:0]     cyc,
  input logic [CYW-1:0]     flast,
  input logic               frame_end,
  input logic               wbank
);
  AST_FP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    fp |=> (cyc == '0)) else $error("frame pulse did not restart count"); // R5

  AST_SELF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!fp && (cyc == flast)) |=> (cyc == '0)) else $error("no wrap at frame end"); // R11

  AST_CYC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cyc <= flast) else $error("count beyond frame"); // R11

  AST_BANK_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (wbank != $past(wbank))) else $error("bank not swapped"); // R7

  AST_SLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((rate == 2'd0) && cyc[0]) |-> $stable(so)) else $error("bit not held 2 clocks"); // R2

  for (genvar o = 0; o < NSTREAM; o++) begin : g_idle
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (o >= f_nout(rate, cfg)) |-> so[o]) else $error("inactive output low"); // R10
  end
endmodule

bind tsi_switch tsi_switch_chk #(.NSTREAM(NSTREAM), .CYW(CYW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fp(fp), .rate(rate), .cfg(cfg), .so(so),
  .cyc(cyc), .flast(flast), .frame_end(frame_end), .wbank(wbank));

// File: tb/sim_tsi_switch.sv
module sim_tsi_switch;
  logic        clk = 1'b0;
  logic        rst_n, fp, cfg, cm_we;
  logic [1:0]  rate;
  logic [7:0]  si, so;
  logic [9:0]  cm_addr;
  logic [11:0] cm_wdata;

  always #5 clk = ~clk;

  tsi_switch u0 (.clk(clk), .rst_n(rst_n), .fp(fp), .rate(rate), .cfg(cfg), .si(si),
                 .so(so), .cm_we(cm_we), .cm_addr(cm_addr), .cm_wdata(cm_wdata));

  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0]  hist [0:3][0:7][0:127];
  logic [11:0] cms  [0:7][0:127];

  function automatic int b_nch(int r);  return r == 0 ? 32 : (r == 1 ? 64 : 128); endfunction
  function automatic int b_nin(int r, int c);
    if (r == 0) return c ? 4 : 8;
    if (r == 1) return c ? 8 : 4;
    return 2;
  endfunction
  function automatic int b_nout(int r, int c); return r == 0 ? (c ? 4 : 8) : (r == 1 ? 4 : 2); endfunction
  function automatic bit b_cok(int r, int c); return !(r == 1 && c == 1); endfunction

  function automatic logic [7:0] exp_byte(int o, int n, int f, int r, int c);
    logic [11:0] e = cms[o][n];
    int ss = int'(e[9:7]);
    int sc = int'(e[6:0]);
    if (!e[11] || ss >= b_nin(r, c) || sc >= b_nch(r)) return 8'hFF;
    if (!(e[10] && b_cok(r, c)) && sc < n) return hist[f % 4][ss][sc];
    return hist[(f + 3) % 4][ss][sc];
  endfunction

  function automatic string kind_of(int o, int n, int r, int c);
    logic [11:0] e = cms[o][n];
    if (!e[11] || int'(e[9:7]) >= b_nin(r, c) || int'(e[6:0]) >= b_nch(r)) return "R9";
    if (e[10]) return "R8";
    return "R7";
  endfunction

  task automatic chk(bit ok, string req, string what, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  task automatic segment(int r, int c, int nfr, bit keep_fp, string tag);
    int nch = b_nch(r), nin = b_nin(r, c), nout = b_nout(r, c);
    int slow = (r == 0);
    int flen = (nch * 8) << slow;
    logic [7:0] obits [0:7];
    rst_n = 0; rate = 2'(r); cfg = c[0]; fp = 0; cm_we = 0; si = '1;
    repeat (2) @(negedge clk);
    chk(so == 8'hFF, "R1", "outputs during reset", so, 8'hFF);
    rst_n = 1;
    @(negedge clk);
    chk(so == 8'hFF, "R1", "outputs after reset", so, 8'hFF);
    // program connection memory (R6 layout)
    for (int o = 0; o < nout; o++) begin
      for (int n = 0; n < nch; n++) begin
        logic [11:0] e;
        e[11]  = ($urandom % 8) != 0;
        e[10]  = $urandom % 2;
        e[9:7] = 3'($urandom % (nin + 1));
        e[6:0] = 7'($urandom % (nch + (nch < 128 ? 4 : 0)));
        if (o == 0 && n == 0) e = {2'b10, 3'd0, 7'(nch - 1)};     // last ch, prior frame
        if (o == 0 && n == 1) e = {2'b10, 3'd0, 7'd0};             // source below
        if (o == 0 && n == 2) e = {2'b10, 3'd0, 7'd2};             // same channel
        if (o == 0 && n == 3) e = {2'b11, 3'd0, 7'd2};             // constant delay
        if (o == 0 && n == 4) e = {2'b00, 3'd0, 7'd1};             // not valid
        if (o == nout - 1 && n == nch - 1) e = {2'b11, 3'(nin - 1), 7'(nch - 1)};
        cms[o][n] = e;
        cm_we = 1; cm_addr = {3'(o), 7'(n)}; cm_wdata = e;
        @(negedge clk);
      end
    end
    cm_we = 0;
    fp = 1;
    for (int f = 0; f < nfr; f++) begin
      for (int s = 0; s < 8; s++)
        for (int n = 0; n < nch; n++) hist[f % 4][s][n] = 8'($urandom);
      for (int k = 0; k < flen; k++) begin
        int b, ch, bp;
        bit smp;
        @(negedge clk);
        fp  = keep_fp && (k == flen - 1);
        b   = k >> slow;
        ch  = b >> 3;
        bp  = b & 7;
        smp = !slow || (k % 2 == 0);
        for (int s = 0; s < 8; s++) si[s] = hist[f % 4][s][ch][7 - bp];
        if (smp) begin
          for (int o = 0; o < 8; o++) obits[o] = {obits[o][6:0], so[o]};
          if (bp == 7 && f >= 1) begin
            for (int o = 0; o < 8; o++) begin
              if (o < nout) begin
                logic [7:0] ex = exp_byte(o, ch, f, r, c);
                chk(obits[o] == ex, $sformatf("%s %s R5 R6", tag, kind_of(o, ch, r, c)),
                    $sformatf("out=%0d ch=%0d frame=%0d", o, ch, f), obits[o], ex);
              end else begin
                chk(obits[o] == 8'hFF, $sformatf("R10 %s", tag),
                    $sformatf("idle out=%0d ch=%0d", o, ch), obits[o], 8'hFF);
              end
            end
          end
        end
      end
    end
    fp = 0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    segment(0, 0, 4, 1, "R2");
    segment(0, 1, 4, 1, "R2");
    segment(1, 0, 4, 1, "R3");
    segment(1, 1, 4, 1, "R3");
    segment(2, 0, 3, 1, "R4");
    segment(2, 1, 3, 0, "R4 R11");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule